// File: doc/BRIEF.md
# Bidirectional-Bus Universal Shift Register

This block is a parameterised register, eight bits wide by default. A two-bit mode input selects one of four actions, and each action takes effect on the rising clock edge. The register can keep its contents, shift toward the high end, shift toward the low end, or capture a whole word from a shared parallel bus. The same bus carries the register contents out. The bus is modelled as three signals: an input path, an output data path and an output-enable. The enclosing logic or pad ring merges them into one bidirectional bus.

The output-enable turns off when either of two active-low enables is high. It also turns off whenever load mode is selected, so an external source can drive the bus without contention. The lowest and highest bits are always presented on two dedicated serial outputs. This lets several stages be chained into a longer shift chain. An active-low reset clears the register at once, with no clock edge needed, and it takes priority over the mode selects and the clock.

Top module: `ushift_bus_reg`

## Requirements
- R1: With mode 2'b00 (keep), the register contents do not change across a rising clock edge.
- R2: With mode 2'b01 (shift up), each rising edge moves bit i into bit i+1 and loads bit 0 from `ser_up_i`.
- R3: With mode 2'b10 (shift down), each rising edge moves bit i into bit i-1 and loads the top bit from `ser_dn_i`.
- R4: With mode 2'b11 (load), the rising edge copies `bus_i` into the register.
- R5: While `rst_n` is low, the register reads zero at once, between clock edges, whatever the mode and clock inputs do.
- R6: When both `en_a_n` and `en_b_n` are low and the mode is not load, `bus_oe_o` is high and `bus_o` shows the register contents.
- R7: When either `en_a_n` or `en_b_n` is high, `bus_oe_o` is low.
- R8: In load mode (2'b11), `bus_oe_o` is low whatever the enables are.
- R9: Keep, shift and load work the same while `bus_oe_o` is low.
- R10: `lsb_o` always equals register bit 0 and `msb_o` always equals the top bit, regardless of the enables.
- R11: When two instances are chained (the low stage's `msb_o` drives the high stage's `ser_up_i`, and the high stage's `lsb_o` drives the low stage's `ser_dn_i`), bits cross between the stages in both shift directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous clear |
| ser_up_i | input | 1 | Serial bit entering bit 0 in shift-up mode |
| ser_dn_i | input | 1 | Serial bit entering the top bit in shift-down mode |
| en_a_n | input | 1 | Active-low bus output enable A |
| en_b_n | input | 1 | Active-low bus output enable B |
| mode_i | input | 2 | Mode: 00 keep, 01 shift up, 10 shift down, 11 load |
| bus_i | input | WIDTH | Bus value seen by the register (load data) |
| bus_o | output | WIDTH | Register contents for the bus driver |
| bus_oe_o | output | 1 | Bus driver enable |
| lsb_o | output | 1 | Register bit 0 |
| msb_o | output | 1 | Register top bit |

## Verification
Every clock cycle, the assertions check the following:
- the keep, both shift and load transitions against the previous cycle's state and inputs;
- that the register reads zero during reset;
- that the bus driver is never on in load mode or while an enable is inactive.

Only the bench scenarios can show the remaining behaviour:
- that reset clears the register between clock edges, not at the next edge;
- that the serial pins follow the register while the bus is released;
- that two chained instances pass bits across their boundary in both directions.

// File: rtl/ushift_pkg.sv
package ushift_pkg;
  typedef enum logic [1:0] {
    MODE_KEEP = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DN   = 2'b10,
    MODE_LOAD = 2'b11
  } mode_t;
endpackage

// File: rtl/ushift_next.sv
module ushift_next
  import ushift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  mode_t            mode_i,
  input  logic [WIDTH-1:0] q_i,
  input  logic             ser_up_i,
  input  logic             ser_dn_i,
  input  logic [WIDTH-1:0] load_i,
  output logic [WIDTH-1:0] nxt_o,
  output logic             en_o
);
  localparam int TOP = WIDTH - 1;

  // per-bit neighbour selection
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic from_below;
    logic from_above;
    if (i == 0) begin : g_low
      assign from_below = ser_up_i;
    end else begin : g_low_mid
      assign from_below = q_i[i-1];
    end
    if (i == TOP) begin : g_high
      assign from_above = ser_dn_i;
    end else begin : g_high_mid
      assign from_above = q_i[i+1];
    end

    always_comb begin
      unique case (mode_i)
        MODE_UP:   nxt_o[i] = from_below;
        MODE_DN:   nxt_o[i] = from_above;
        MODE_LOAD: nxt_o[i] = load_i[i];
        default:   nxt_o[i] = q_i[i];
      endcase
    end
  end

  assign en_o = (mode_i != MODE_KEEP);
endmodule

// File: rtl/ushift_store.sv
module ushift_store #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_r;
  logic [WIDTH-1:0] q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (en_i) q_nxt = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q_o = q_r;

  // R1: a disabled clock enable leaves the contents unchanged
  a_r1_keep_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(q_r));
endmodule

// File: rtl/ushift_bus_drv.sv
module ushift_bus_drv
  import ushift_pkg::*;
(
  input  logic  en_a_n,
  input  logic  en_b_n,
  input  mode_t mode_i,
  output logic  oe_o
);
  logic enables_on;
  logic load_sel;

  always_comb begin
    enables_on = !en_a_n && !en_b_n;
    load_sel   = (mode_i == MODE_LOAD);
    oe_o       = enables_on && !load_sel;
  end
endmodule

// File: rtl/ushift_bus_reg.sv
module ushift_bus_reg
  import ushift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_up_i,
  input  logic             ser_dn_i,
  input  logic             en_a_n,
  input  logic             en_b_n,
  input  logic [1:0]       mode_i,
  input  logic [WIDTH-1:0] bus_i,
  output logic [WIDTH-1:0] bus_o,
  output logic             bus_oe_o,
  output logic             lsb_o,
  output logic             msb_o
);
  localparam int TOP = WIDTH - 1;

  mode_t            mode;
  logic [WIDTH-1:0] q;
  logic [WIDTH-1:0] q_nxt;
  logic             q_en;

  assign mode = mode_t'(mode_i);

  ushift_next #(.WIDTH(WIDTH)) u_next (
    .mode_i   (mode),
    .q_i      (q),
    .ser_up_i (ser_up_i),
    .ser_dn_i (ser_dn_i),
    .load_i   (bus_i),
    .nxt_o    (q_nxt),
    .en_o     (q_en)
  );

  ushift_store #(.WIDTH(WIDTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (q_en),
    .d_i   (q_nxt),
    .q_o   (q)
  );

  ushift_bus_drv u_drv (
    .en_a_n (en_a_n),
    .en_b_n (en_b_n),
    .mode_i (mode),
    .oe_o   (bus_oe_o)
  );

  assign bus_o = q;
  assign lsb_o = q[0];
  assign msb_o = q[TOP];

  // R2: shift up moves every bit one place higher
  a_r2_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b01) |=> (q == {$past(q[TOP-1:0]), $past(ser_up_i)}));

  // R3: shift down moves every bit one place lower
  a_r3_shift_dn: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b10) |=> (q == {$past(ser_dn_i), $past(q[TOP:1])}));

  // R4: load captures the bus
  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b11) |=> (q == $past(bus_i)));

  // R5: contents are zero while reset is held
  a_r5_reset_zero: assert property (@(posedge clk)
    !rst_n |-> (q == '0));

  // R7, R8: no bus drive when released or while loading
  a_r8_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == 2'b11) || en_a_n || en_b_n) |-> !bus_oe_o);
endmodule

// File: tb/ushift_bus_reg_tb.sv
`timescale 1ns/1ps
module ushift_bus_reg_tb_top;
  typedef struct packed {
    logic [1:0] mode;
    logic       ea;
    logic       eb;
    logic       su;
    logic       sd;
    logic [7:0] ld;
    logic [7:0] exp_q;
    logic       exp_oe;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5, 1'b0}, // R4 R8
    '{2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hA5, 1'b1}, // R1 R6
    '{2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h4B, 1'b1}, // R2
    '{2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h96, 1'b1}, // R2
    '{2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'hCB, 1'b1}, // R3
    '{2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h65, 1'b0}, // R3 R7 R9
    '{2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h65, 1'b0}, // R1 R7 R9
    '{2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'hCB, 1'b0}, // R2 R7 R9
    '{2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hCB, 1'b1}, // R1 R6
    '{2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 8'h3C, 8'h3C, 1'b0}, // R4 R9
    '{2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h3C, 1'b1}, // R1
    '{2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h1E, 1'b1}, // R3
    '{2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h3C, 1'b1}  // R2
  };

  logic       clk;
  logic       rst_n;
  logic       su, sd, ea, eb;
  logic [1:0] mode;
  logic [7:0] tb_drv;
  logic [7:0] bus_o, bus_w;
  logic       bus_oe, lsb, msb;

  int n_chk;
  int n_err;
  bit done;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // external bus source, driving only in load mode
  assign bus_w = bus_oe ? bus_o : ((mode == 2'b11) ? tb_drv : 8'h00);

  ushift_bus_reg #(.WIDTH(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .ser_up_i(su), .ser_dn_i(sd),
    .en_a_n(ea), .en_b_n(eb), .mode_i(mode), .bus_i(bus_w),
    .bus_o(bus_o), .bus_oe_o(bus_oe), .lsb_o(lsb), .msb_o(msb)
  );

  // two chained stages
  logic [1:0] c_mode;
  logic [7:0] c_lo_drv, c_hi_drv, c_lo_o, c_hi_o, c_lo_w, c_hi_w;
  logic       c_lo_oe, c_hi_oe, c_lo_lsb, c_lo_msb, c_hi_lsb, c_hi_msb;

  assign c_lo_w = c_lo_oe ? c_lo_o : c_lo_drv;
  assign c_hi_w = c_hi_oe ? c_hi_o : c_hi_drv;

  ushift_bus_reg #(.WIDTH(8)) casc_lo_i (
    .clk(clk), .rst_n(rst_n), .ser_up_i(1'b0), .ser_dn_i(c_hi_lsb),
    .en_a_n(1'b0), .en_b_n(1'b0), .mode_i(c_mode), .bus_i(c_lo_w),
    .bus_o(c_lo_o), .bus_oe_o(c_lo_oe), .lsb_o(c_lo_lsb), .msb_o(c_lo_msb)
  );

  ushift_bus_reg #(.WIDTH(8)) casc_hi_i (
    .clk(clk), .rst_n(rst_n), .ser_up_i(c_lo_msb), .ser_dn_i(1'b0),
    .en_a_n(1'b0), .en_b_n(1'b0), .mode_i(c_mode), .bus_i(c_hi_w),
    .bus_o(c_hi_o), .bus_oe_o(c_hi_oe), .lsb_o(c_hi_lsb), .msb_o(c_hi_msb)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_chk = 0; n_err = 0; done = 1'b0;
    rst_n = 1'b1; su = 0; sd = 0; ea = 0; eb = 0; mode = 2'b00; tb_drv = 8'h00;
    c_mode = 2'b00; c_lo_drv = 8'h00; c_hi_drv = 8'h00;
    #2 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk("R5 reset state", bus_o, 8'h00);
    chk("R5 reset serial", {6'd0, msb, lsb}, 8'h00);
    chk("R6 reset drive", {7'd0, bus_oe}, 8'h01);
    @(negedge clk) rst_n = 1'b1;

    // vector table
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      mode = VECS[k].mode; ea = VECS[k].ea; eb = VECS[k].eb;
      su = VECS[k].su; sd = VECS[k].sd; tb_drv = VECS[k].ld;
      @(posedge clk);
      #1;
      // R10 serial pins follow the ends, enables regardless
      chk("R10 serial ends", {6'd0, msb, lsb},
          {6'd0, VECS[k].exp_q[7], VECS[k].exp_q[0]});
      chk((VECS[k].mode == 2'b11) ? "R8 load release" :
          (VECS[k].exp_oe ? "R6 drive on" : "R7 drive off"),
          {7'd0, bus_oe}, {7'd0, VECS[k].exp_oe});
      if (VECS[k].exp_oe)
        chk(mode_tag(VECS[k].mode), bus_o, VECS[k].exp_q);
      else if (VECS[k].mode == 2'b11)
        chk("R9 load while released", {6'd0, msb, lsb},
            {6'd0, VECS[k].exp_q[7], VECS[k].exp_q[0]});
    end

    // R5: reset between edges, overriding mode and clock
    @(negedge clk);
    mode = 2'b11; tb_drv = 8'hFF; ea = 0; eb = 0;
    @(posedge clk);
    #2 rst_n = 1'b0;
    #1;
    chk("R5 async clear mid-cycle", {6'd0, msb, lsb}, 8'h00);
    @(posedge clk);
    #1;
    chk("R5 overrides load", {6'd0, msb, lsb}, 8'h00);
    @(negedge clk);
    mode = 2'b00;
    #1;
    chk("R5 contents zero", bus_o, 8'h00);
    rst_n = 1'b1;

    // R11: chained stages
    @(negedge clk);
    c_mode = 2'b11; c_lo_drv = 8'h81; c_hi_drv = 8'h00;
    @(negedge clk);
    c_mode = 2'b01;
    @(posedge clk);
    #1;
    chk("R11 chain up low", c_lo_o, 8'h02);
    chk("R11 chain up high", c_hi_o, 8'h01);
    @(negedge clk);
    c_mode = 2'b10;
    @(posedge clk);
    #1;
    chk("R11 chain down low", c_lo_o, 8'h81);
    chk("R11 chain down high", c_hi_o, 8'h00);

    finish_run();
  end
endmodule